// File: doc/BRIEF.md
# Supply and Oscillator Status Register

This block is the 8-bit control and status register of a real-time clock. It holds four things. The first is a bit that selects the supply-monitor threshold. The second is a sticky result bit from the supply monitor. The third is a free scratch bit. The fourth is a sticky flag that records an oscillator halt. The register also holds three event flags: a periodic-interrupt flag and two alarm flags. A serial front end reaches the register through a write strobe with a data byte and a read strobe. The analog side supplies a comparator result, an oscillator-halt detect and the chip-enable level.

A bit may mean one thing on a write and another on a read. All status flags can be cleared only by writing 0 to them, and writing 1 to a flag leaves it unchanged. When the oscillator is found halted, the whole register returns to its default value. Halt sensing works only while chip enable is low. While the low-voltage result is set, the block holds the supply monitor disabled. The threshold select bit is brought out so that it can drive the comparator reference.

Top module: `rtc_supply_status`

## Requirements
- R1: While `rst_n` is low, the register takes its default value 0x10: every bit is 0 except the halt flag at bit 4. In this state `rd_data` is 0x00, `mon_enable` is 1 and `thresh_sel` is 0.
- R2: A cycle with `rd_en` high loads `rd_data` on that clock edge with the read view. The read view is bit 7 threshold select, bit 6 low-voltage result, bit 5 scratch, bit 4 halt flag, bit 3 zero, bit 2 periodic flag, and bits 1 and 0 the alarm flags. When `rd_en` is low, `rd_data` keeps its value.
- R3: A write loads bit 7 of `wr_data` into the threshold select, and `thresh_sel` shows it. Code 0 selects the 2.1 V level and code 1 selects the 1.6 V level.
- R4: While the low-voltage result is 0, `mon_enable` is 1 and a high `low_supply` sets the result on the next edge. Once the result is 1, it stays 1 and `mon_enable` is 0 until the result is cleared.
- R5: A write with bit 6 at 0 clears the low-voltage result, which restarts monitoring. A write with bit 6 at 1 has no effect on it. If `low_supply` is high while monitoring is active and a clearing write arrives in the same cycle, the result is set.
- R6: A write loads bit 5 into the scratch bit, and the scratch bit reads back exactly what was written.
- R7: When `osc_halt` is high while `chip_en` is low, the next edge forces the register to 0x10. This takes priority over a write in the same cycle.
- R8: `osc_halt` has no effect while `chip_en` is high.
- R9: The halt flag clears only on a write with bit 4 at 0. A write with bit 4 at 1 leaves the flag at 1.
- R10: A high bit of `flag_evt` sets the matching flag (bit 2 of `flag_evt` sets read bit 2, and so on down to bit 0). A write with that bit at 0 clears the flag, and a write with that bit at 1 has no effect. If an event and a clearing write arrive in the same cycle, the event wins.
- R11: Read bit 3 is always 0, whatever value is written to bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data in the write layout |
| rd_en | input | 1 | Read strobe; loads `rd_data` on the next edge |
| low_supply | input | 1 | Comparator result, 1 = supply below threshold |
| osc_halt | input | 1 | Oscillator-halt detect, 1 = halted |
| chip_en | input | 1 | Chip-enable level; halt sensing only while low |
| flag_evt | input | 3 | Set pulses for the periodic flag (bit 2) and the two alarm flags (bits 1, 0) |
| rd_data | output | 8 | Registered read view of the register |
| mon_enable | output | 1 | Supply monitor enable, 0 while the low-voltage result is set |
| thresh_sel | output | 1 | Threshold code, 0 = 2.1 V, 1 = 1.6 V |

## Verification
A table of writes covers four groups of cases. The first sets every writable bit to 1 over stored flags, which separates a flag kept on a written 1 from a flag cleared on a written 0. The second writes 0 in the same cycle as a set, which shows which of the two has priority. The third asserts the halt detect with chip enable high and then low, and in the low case adds a write in the same cycle, which tests the chip-enable gating and the forced default. The fourth writes ones and zeros to the reserved bit and to the halt position, which separates a bit that is discarded from a flag that can only be cleared. Directed steps then change the state with no read strobe and apply a reset in the middle of the run, which confirms that `rd_data` holds its value and that the defaults return.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
   localparam int REG_W      = 8;
   localparam int NUM_FLAGS  = 3;
   // bit positions that the serial front end decodes
   localparam int POS_THR    = 7;
   localparam int POS_LOWV   = 6;
   localparam int POS_SCR    = 5;
   localparam int POS_HALT   = 4;
   localparam int POS_RSV    = 3;
   localparam logic [REG_W-1:0] DEF_VIEW = 8'h10;
endpackage

// File: rtl/rtc_sticky_bit.sv
// Sticky status bit: set by an event, cleared by a zero write,
// forced to DEF_VAL by reset or by the default-force input.
module rtc_sticky_bit #(
   parameter bit DEF_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_def,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   generate
      if (SET_WINS) begin : g_set_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= DEF_VAL;
            else if (force_def) q <= DEF_VAL;
            else if (set_i)     q <= 1'b1;
            else if (clr_i)     q <= 1'b0;
         end
      end else begin : g_clr_pri
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= DEF_VAL;
            else if (force_def) q <= DEF_VAL;
            else if (clr_i)     q <= 1'b0;
            else if (set_i)     q <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_stat_readback.sv
// Registered read port: loads the view on a read strobe, else holds.
module rtc_stat_readback #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en,
   input  logic [W-1:0] view,
   output logic [W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= view;
   end
endmodule

// File: rtl/rtc_supply_status.sv
module rtc_supply_status
   import rtc_stat_pkg::*;
#(
   parameter int DATA_W    = REG_W,
   parameter int FLAG_CNT  = NUM_FLAGS,
   parameter bit EVT_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              low_supply,
   input  logic              osc_halt,
   input  logic              chip_en,
   input  logic [FLAG_CNT-1:0] flag_evt,
   output logic [DATA_W-1:0] rd_data,
   output logic              mon_enable,
   output logic              thresh_sel
);
   localparam int FLAG_TOP = FLAG_CNT - 1;

   generate
      if (DATA_W != REG_W || FLAG_CNT != NUM_FLAGS || FLAG_TOP >= POS_RSV) begin : g_bad_cfg
         $error("rtc_supply_status: layout needs DATA_W=8 and FLAG_CNT=3");
      end
   endgenerate

   logic halt_evt;
   logic thr_q, scr_q, lowv_q, halt_q;
   logic [FLAG_CNT-1:0] flag_q;
   logic rsv_zero;
   logic [DATA_W-1:0] view;

   // halt sensing runs only while chip enable is low
   assign halt_evt = osc_halt & ~chip_en;

   // plain writable bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= DEF_VIEW[POS_THR];
         scr_q <= DEF_VIEW[POS_SCR];
      end else if (halt_evt) begin
         thr_q <= DEF_VIEW[POS_THR];
         scr_q <= DEF_VIEW[POS_SCR];
      end else if (wr_en) begin
         thr_q <= wr_data[POS_THR];
         scr_q <= wr_data[POS_SCR];
      end
   end

   rtc_sticky_bit #(.DEF_VAL(DEF_VIEW[POS_LOWV]), .SET_WINS(EVT_WINS)) u_lowv (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_def (halt_evt),
      .set_i     (low_supply & ~lowv_q),
      .clr_i     (wr_en & ~wr_data[POS_LOWV]),
      .q         (lowv_q)
   );

   rtc_sticky_bit #(.DEF_VAL(DEF_VIEW[POS_HALT]), .SET_WINS(1'b1)) u_halt (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_def (1'b0),
      .set_i     (halt_evt),
      .clr_i     (wr_en & ~wr_data[POS_HALT]),
      .q         (halt_q)
   );

   generate
      for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
         rtc_sticky_bit #(.DEF_VAL(DEF_VIEW[i]), .SET_WINS(EVT_WINS)) u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_def (halt_evt),
            .set_i     (flag_evt[i]),
            .clr_i     (wr_en & ~wr_data[i]),
            .q         (flag_q[i])
         );
      end
   endgenerate

   // reserved position: written value is discarded, reads as zero
   assign rsv_zero = 1'b0 & wr_data[POS_RSV];

   always_comb begin
      view           = '0;
      view[POS_THR]  = thr_q;
      view[POS_LOWV] = lowv_q;
      view[POS_SCR]  = scr_q;
      view[POS_HALT] = halt_q;
      view[POS_RSV]  = rsv_zero;
      view[FLAG_TOP:0] = flag_q;
   end

   rtc_stat_readback #(.W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .view    (view),
      .rd_data (rd_data)
   );

   assign mon_enable = ~lowv_q;
   assign thresh_sel = thr_q;
endmodule

// File: rtl/rtc_supply_status_chk.sv
module rtc_supply_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       rd_en,
   input logic       low_supply,
   input logic       osc_halt,
   input logic       chip_en,
   input logic [7:0] rd_data,
   input logic       mon_enable,
   input logic       thresh_sel
);
   // R7
   halt_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_halt && !chip_en) |=> (!thresh_sel && mon_enable));
   // R3
   thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(osc_halt && !chip_en)) |=> (thresh_sel == $past(wr_data[7])));
   // R4
   lowv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_enable && !(wr_en && !wr_data[6]) && !(osc_halt && !chip_en)) |=> !mon_enable);
   // R4
   lowv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_enable && low_supply && !(osc_halt && !chip_en)) |=> !mon_enable);
   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   // R11
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_data[3]);
endmodule

bind rtc_supply_status rtc_supply_status_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_en      (rd_en),
   .low_supply (low_supply),
   .osc_halt   (osc_halt),
   .chip_en    (chip_en),
   .rd_data    (rd_data),
   .mon_enable (mon_enable),
   .thresh_sel (thresh_sel)
);

// File: tb/rtc_supply_status_test.sv
module rtc_supply_status_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic       low_supply = 1'b0;
   logic       osc_halt = 1'b0;
   logic       chip_en = 1'b1;
   logic [2:0] flag_evt = '0;
   logic [7:0] rd_data;
   logic       mon_enable;
   logic       thresh_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rtc_supply_status uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .low_supply(low_supply), .osc_halt(osc_halt),
      .chip_en(chip_en), .flag_evt(flag_evt), .rd_data(rd_data),
      .mon_enable(mon_enable), .thresh_sel(thresh_sel)
   );

   // {wr, data, low_supply, osc_halt, chip_en, flag_evt, expected read}
   localparam int NV = 15;
   localparam logic [22:0] VEC [0:NV-1] = '{
      {1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 8'h00}, // R9 R5 clear all
      {1'b1, 8'hA7, 1'b0, 1'b0, 1'b1, 3'b000, 8'hA0}, // R3 R6 R10 R11
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'b000, 8'hE0}, // R4 detect
      {1'b1, 8'hE0, 1'b0, 1'b0, 1'b1, 3'b000, 8'hE0}, // R5 write 1 keeps
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b111, 8'hE7}, // R10 set flags
      {1'b1, 8'hE5, 1'b0, 1'b0, 1'b1, 3'b000, 8'hE5}, // R10 clear bit 1
      {1'b1, 8'h81, 1'b0, 1'b0, 1'b1, 3'b000, 8'h81}, // R5 R6 R10
      {1'b1, 8'h81, 1'b1, 1'b0, 1'b1, 3'b000, 8'hC1}, // R5 detect beats clear
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 3'b000, 8'hC1}, // R8 ce high
      {1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 8'h10}, // R7 beats write
      {1'b1, 8'h18, 1'b0, 1'b0, 1'b1, 3'b000, 8'h10}, // R9 write 1 keeps
      {1'b1, 8'h2C, 1'b0, 1'b0, 1'b1, 3'b000, 8'h20}, // R9 R11
      {1'b1, 8'h20, 1'b0, 1'b0, 1'b1, 3'b010, 8'h22}, // R10 event wins
      {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'b000, 8'h62}, // R4
      {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, 8'h10}  // R7
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic step(input logic w, input logic [7:0] d, input logic l,
                       input logic h, input logic ce, input logic [2:0] e);
      wr_en = w; wr_data = d; low_supply = l; osc_halt = h; chip_en = ce; flag_evt = e;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; low_supply = 1'b0; osc_halt = 1'b0;
      chip_en = 1'b1; flag_evt = '0;
   endtask

   task automatic read_chk(input string tag, input logic [7:0] exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(tag, rd_data, exp);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rd_data at reset", rd_data, 8'h00);
      check("R1 mon_enable at reset", {7'b0, mon_enable}, 8'h01);
      check("R1 thresh_sel at reset", {7'b0, thresh_sel}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R1 R2 default view", 8'h10);

      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         v = VEC[i];
         step(v[22], v[21:14], v[13], v[12], v[11], v[10:8]);
         check($sformatf("R3 thresh_sel row %0d", i), {7'b0, thresh_sel}, {7'b0, v[7]});
         check($sformatf("R4 mon_enable row %0d", i), {7'b0, mon_enable}, {7'b0, ~v[6]});
         read_chk($sformatf("R2 vector row %0d", i), v[7:0]);
      end

      // R2 hold without a read strobe
      step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'b000);
      check("R2 rd_data holds without rd_en", rd_data, 8'h10);
      read_chk("R4 R2 view after detect", 8'h50);
      check("R4 monitor off", {7'b0, mon_enable}, 8'h00);

      // R1 reset in the middle of the run
      step(1'b1, 8'hA7, 1'b0, 1'b0, 1'b1, 3'b101);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rd_data cleared by reset", rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R1 defaults after reset", 8'h10);
      check("R1 mon_enable after reset", {7'b0, mon_enable}, 8'h01);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule